// File: doc/BRIEF.md
# Context-Keyed Two-Level Page Table Walker

The walker turns a 32-bit virtual address of the running process into a physical address by reading translation entries from memory. A 4-bit context ID is placed above the virtual address to form a 36-bit extended address. The upper 23 bits of that address are the virtual page number and the low 13 bits are the byte offset, so the smallest page is 8 KB. The context ID and the top virtual bits select a word in a first-level directory. The frame number found there is added to the middle virtual bits to reach a second-level entry. The frame number of that second-level entry, joined to the page offset, is the physical address. A segment option ends the walk after the first level. The first-level frame is then joined to a 24-bit offset, which gives 16 MB segments and a 46-bit physical address.

Every entry is a 32-bit word. Bits 31:10 hold the frame number, and a frame of zero marks the entry as invalid. Bits 8:6 are the permissions: bit 6 allows reads, bit 7 allows writes and bit 8 allows execution. Bit 5 is the dirty flag and bit 4 the accessed flag. Bits 9 and 3:0 are carried through untouched. After a successful walk the final entry is written back with its flags updated, and then a one-cycle completion pulse returns the result or a fault code. Only one walk runs at a time. Memory is reached through a word-addressed request channel with a valid/ready handshake and a read-data valid strobe.

Top module: `ctx_walker`

## Requirements
- R1: The first-level entry is read from word address L1_BASE + {context ID, vaddr[31:24]}, truncated to MEM_AW bits.
- R2: In page mode the second-level entry is read from word address (first-level bits 31:10) + vaddr[23:13].
- R3: A successful page walk returns rsp_paddr = {11'b0, second-level bits 31:10, vaddr[12:0]} with rsp_fault = 0 and issues exactly two reads.
- R4: A walk with req_seg = 1 issues exactly one read and, on success, returns rsp_paddr = {first-level bits 31:10, vaddr[23:0]}.
- R5: An entry read with frame bits 31:10 equal to zero, at either level, ends the walk with rsp_fault = 1 (page fault), rsp_paddr = 0 and no memory write.
- R6: The permissions are checked on the final entry only. Access code 0 (read) needs bit 6, code 1 (write) needs bit 7, code 2 (execute) needs bit 8, and code 3 is never allowed. A denied access returns rsp_fault = 2, rsp_paddr = 0, and the entry is left unchanged in memory.
- R7: A successful walk writes the final entry back to its own address before done, with bit 4 set, bit 5 set for a write access (otherwise kept), and all other bits unchanged.
- R8: A memory request holds its address and kind stable until it is accepted, and each walk issues exactly the reads and writes it needs, whatever the stalls.
- R9: After reset, req_ready = 1 and busy, done and mem_req_valid are 0. done is a one-cycle pulse during busy, and in the cycle after it busy is 0 and req_ready is 1.
- R10: With mem_req_ready held high and read data one cycle after the accepting edge, done rises after the acceptance edge by 5 edges for page success, 3 for segment success, 2 for a first-level fault and 4 for a second-level fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_cid | input | 4 | Context ID |
| req_acc | input | 2 | Access: 0 read, 1 write, 2 execute, 3 reserved |
| req_seg | input | 1 | Segment mode, single-level walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_paddr | output | 46 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | MEM_AW | Word address |
| mem_req_wdata | output | 32 | Write-back entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
For every walk the bench counts clock edges from the edge that accepts the request until done is seen, and compares that count with the figures in R10 while the memory never stalls. Outputs are sampled one time unit after each edge, so registered results are read only once they are settled. Fault code, physical address, write-back address and data, and the read and write counts are checked in the done cycle against a bench model that walks its own copy of memory. The busy release is checked one edge later. During the stalled phase the latency check is skipped, and only the results and the access counts are compared.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int VA_W      = 32;
  localparam int CID_W     = 4;
  localparam int OFF_W     = 13;
  localparam int L1_IDX_W  = 8;
  localparam int L2_IDX_W  = 11;
  localparam int SEG_OFF_W = 24;
  localparam int ENT_W     = 32;
  localparam int FRAME_LSB = 10;
  localparam int FRAME_W   = ENT_W - FRAME_LSB;
  localparam int A_BIT     = 4;
  localparam int D_BIT     = 5;
  localparam int PROT_LSB  = 6;
  localparam int PROT_W    = 3;
  localparam int PA_W      = FRAME_W + SEG_OFF_W;
  localparam int WADDR_W   = 32;

  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_EXEC, ACC_RSVD} acc_e;
  typedef enum logic [1:0] {FLT_NONE, FLT_PAGE, FLT_PROT, FLT_UNUSED} flt_e;
  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_WB, S_DONE
  } walk_st_e;

  function automatic logic [WADDR_W-1:0] dir_word(input logic [WADDR_W-1:0] base,
                                                  input logic [CID_W-1:0] cid,
                                                  input logic [L1_IDX_W-1:0] idx);
    return base + WADDR_W'({cid, idx});
  endfunction

  function automatic logic [WADDR_W-1:0] tbl_word(input logic [FRAME_W-1:0] frame,
                                                  input logic [L2_IDX_W-1:0] idx);
    return WADDR_W'(frame) + WADDR_W'(idx);
  endfunction

  function automatic logic [PA_W-1:0] page_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [OFF_W-1:0] off);
    return PA_W'({frame, off});
  endfunction

  function automatic logic [PA_W-1:0] seg_pa(input logic [FRAME_W-1:0] frame,
                                             input logic [SEG_OFF_W-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic perm_ok(input logic [PROT_W-1:0] prot, input acc_e acc);
    case (acc)
      ACC_READ:  return prot[0];
      ACC_WRITE: return prot[1];
      ACC_EXEC:  return prot[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [ENT_W-1:0] mark_used(input logic [ENT_W-1:0] ent, input acc_e acc);
    logic [ENT_W-1:0] r;
    r = ent;
    r[A_BIT] = 1'b1;
    if (acc == ACC_WRITE) r[D_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter logic [MEM_AW-1:0] L1_BASE = '0
) (
  input  logic [CID_W-1:0]   cid,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [FRAME_W-1:0] frame,
  input  logic               seg,
  output logic [MEM_AW-1:0]  dir_addr,
  output logic [MEM_AW-1:0]  tbl_addr,
  output logic [PA_W-1:0]    paddr
);
  localparam logic [WADDR_W-1:0] BASE_W = WADDR_W'(L1_BASE);

  assign dir_addr = MEM_AW'(dir_word(BASE_W, cid, vaddr[VA_W-1 -: L1_IDX_W]));
  assign tbl_addr = MEM_AW'(tbl_word(frame, vaddr[OFF_W +: L2_IDX_W]));
  assign paddr    = seg ? seg_pa(frame, vaddr[SEG_OFF_W-1:0])
                        : page_pa(frame, vaddr[OFF_W-1:0]);
endmodule

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
  import pgw_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  input  logic [PROT_W-1:0]  prot,
  input  acc_e               acc,
  input  logic               final_lvl,
  output flt_e               fault
);
  always_comb begin
    if (frame == '0)                         fault = FLT_PAGE;
    else if (final_lvl && !perm_ok(prot, acc)) fault = FLT_PROT;
    else                                     fault = FLT_NONE;
  end
endmodule

// File: rtl/ctx_walker.sv
module ctx_walker
  import pgw_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter logic [MEM_AW-1:0] L1_BASE = MEM_AW'(24'h10_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [3:0]        req_cid,
  input  logic [1:0]        req_acc,
  input  logic              req_seg,
  output logic              busy,
  output logic              done,
  output logic [1:0]        rsp_fault,
  output logic [45:0]       rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [MEM_AW-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  walk_st_e            state_q, state_d;
  logic [VA_W-1:0]     va_q;
  logic [CID_W-1:0]    cid_q;
  acc_e                acc_q;
  logic                seg_q;
  logic [ENT_W-1:0]    ent_q;
  logic [MEM_AW-1:0]   ent_addr_q;
  flt_e                fault_q;
  logic [PA_W-1:0]     paddr_q;

  logic [MEM_AW-1:0]   dir_addr, tbl_addr;
  logic [PA_W-1:0]     pa_calc;
  flt_e                chk_fault;

  // named events for the checks below
  logic walk_start, rsp_take, req_fire, wb_fire, final_lvl;
  assign walk_start = req_valid && (state_q == S_IDLE);
  assign rsp_take   = mem_rsp_valid && (state_q == S_L1_WAIT || state_q == S_L2_WAIT);
  assign req_fire   = mem_req_valid && mem_req_ready;
  assign wb_fire    = req_fire && mem_req_write;
  assign final_lvl  = seg_q || (state_q == S_L2_WAIT);

  pgw_addr_gen #(.MEM_AW(MEM_AW), .L1_BASE(L1_BASE)) u_addr (
    .cid      (cid_q),
    .vaddr    (va_q),
    .frame    (ent_q[FRAME_LSB +: FRAME_W]),
    .seg      (seg_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr),
    .paddr    (pa_calc)
  );

  pgw_entry_check u_chk (
    .frame     (mem_rsp_data[FRAME_LSB +: FRAME_W]),
    .prot      (mem_rsp_data[PROT_LSB +: PROT_W]),
    .acc       (acc_q),
    .final_lvl (final_lvl),
    .fault     (chk_fault)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (req_valid) state_d = S_L1_REQ;
      S_L1_REQ:  if (mem_req_ready) state_d = S_L1_WAIT;
      S_L1_WAIT: if (mem_rsp_valid) begin
                   if (chk_fault != FLT_NONE) state_d = S_DONE;
                   else if (seg_q)            state_d = S_WB;
                   else                       state_d = S_L2_REQ;
                 end
      S_L2_REQ:  if (mem_req_ready) state_d = S_L2_WAIT;
      S_L2_WAIT: if (mem_rsp_valid) state_d = (chk_fault != FLT_NONE) ? S_DONE : S_WB;
      S_WB:      if (mem_req_ready) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (state_q)
      S_L1_REQ: begin mem_req_valid = 1'b1; mem_req_addr = dir_addr; end
      S_L2_REQ: begin mem_req_valid = 1'b1; mem_req_addr = tbl_addr; end
      S_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ent_addr_q;
        mem_req_wdata = mark_used(ent_q, acc_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      va_q       <= '0;
      cid_q      <= '0;
      acc_q      <= ACC_READ;
      seg_q      <= 1'b0;
      ent_q      <= '0;
      ent_addr_q <= '0;
      fault_q    <= FLT_NONE;
      paddr_q    <= '0;
    end else begin
      state_q <= state_d;
      if (walk_start) begin
        va_q  <= req_vaddr;
        cid_q <= req_cid;
        acc_q <= acc_e'(req_acc);
        seg_q <= req_seg;
      end
      if (req_fire && !mem_req_write) ent_addr_q <= mem_req_addr;
      if (rsp_take) begin
        ent_q <= mem_rsp_data;
        if (chk_fault != FLT_NONE) begin
          fault_q <= chk_fault;
          paddr_q <= '0;
        end
      end
      if (wb_fire) begin
        fault_q <= FLT_NONE;
        paddr_q <= pa_calc;
      end
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;

  // R8: a stalled request keeps its address and kind
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R9: busy clears right after the completion pulse
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  // R9: a new walk only starts from idle and keeps the walker busy
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> busy && !req_ready && !done);

  // R5/R6: a faulting entry finishes the walk without any write
  p_fault_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && chk_fault != FLT_NONE |=> done && !mem_req_valid);

  // R7: the written-back entry carries the accessed flag and a valid frame
  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> mem_req_wdata[A_BIT] && (mem_req_wdata[FRAME_LSB +: FRAME_W] != '0));

  // R7: dirty flag only changes for write accesses
  p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire && acc_q != ACC_WRITE |-> mem_req_wdata[D_BIT] == ent_q[D_BIT]);

  // R4: segment walks never reach the second level
  p_seg_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_L2_REQ |-> !seg_q);

  // R9: the completion pulse never overlaps a memory request
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid && busy);
endmodule

// File: tb/ctx_walker_tb_top.sv
module ctx_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam logic [AW-1:0] DIR_BASE = 24'h10_0000;

  logic clk, rst_n;
  logic req_valid, req_ready, req_seg, busy, done;
  logic [31:0] req_vaddr;
  logic [3:0]  req_cid;
  logic [1:0]  req_acc, rsp_fault;
  logic [45:0] rsp_paddr;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [AW-1:0] last_wa;
  logic [31:0]   last_wd;
  bit stall_en = 0;
  bit [31:0] mem [int unsigned];

  ctx_walker #(.MEM_AW(AW), .L1_BASE(DIR_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_cid(req_cid), .req_acc(req_acc), .req_seg(req_seg),
    .busy(busy), .done(done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [31:0] rd(input logic [AW-1:0] a);
    int unsigned k;
    k = {8'h0, a};
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  // memory: read data valid one cycle after the accepting edge
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[{8'h0, mem_req_addr}] = mem_req_wdata;
        last_wa = mem_req_addr;
        last_wd = mem_req_wdata;
        wr_cnt++;
      end else begin
        mem_rsp_data  <= rd(mem_req_addr);
        mem_rsp_valid <= 1'b1;
        rd_cnt++;
      end
    end
  end

  always @(negedge clk) mem_req_ready <= stall_en ? 1'($urandom_range(0, 1)) : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit allowed(input logic [2:0] p, input logic [1:0] acc);
    case (acc)
      2'd0: return p[0];
      2'd1: return p[1];
      2'd2: return p[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [AW-1:0] l1_of(input logic [3:0] cid, input logic [31:0] va);
    return AW'(DIR_BASE + AW'({cid, va[31:24]}));
  endfunction

  function automatic logic [AW-1:0] l2_of(input logic [31:0] e1, input logic [31:0] va);
    logic [31:0] s;
    s = 32'(e1[31:10]) + 32'(va[23:13]);
    return s[AW-1:0];
  endfunction

  function automatic logic [31:0] mk(input logic [21:0] fr, input logic [2:0] p, input logic [5:0] lo);
    return {fr, 1'b0, p, lo};
  endfunction

  function automatic logic [31:0] rnd_ent(input bit zero);
    logic [21:0] fr;
    fr = zero ? 22'h0 : 22'($urandom_range(1, 22'h3F_FFFF));
    return {fr, 10'($urandom)};
  endfunction

  task automatic place(input logic [31:0] va, input logic [3:0] cid, input bit seg,
                       input logic [31:0] e1, input logic [31:0] e2);
    mem[{8'h0, l1_of(cid, va)}] = e1;
    if (!seg && e1[31:10] != 0) mem[{8'h0, l2_of(e1, va)}] = e2;
  endtask

  task automatic walk(input logic [31:0] va, input logic [3:0] cid, input logic [1:0] acc, input bit seg);
    logic [1:0]  ef;
    logic [45:0] ep;
    logic [AW-1:0] wa;
    logic [31:0] e1, e2, ent, wd;
    int lat, nrd, k;
    bit got, wb;
    string t;
    // bench model of the walk
    wa = l1_of(cid, va); e1 = rd(wa); nrd = 1; wb = 0; ep = '0; wd = '0; e2 = '0;
    if (e1[31:10] == 0) begin ef = 2'd1; lat = 2; end
    else if (seg) begin
      ent = e1;
      if (!allowed(e1[8:6], acc)) begin ef = 2'd2; lat = 2; end
      else begin ef = 2'd0; lat = 3; wb = 1; ep = {e1[31:10], va[23:0]}; end
    end else begin
      wa = l2_of(e1, va); e2 = rd(wa); nrd = 2; ent = e2;
      if (e2[31:10] == 0) begin ef = 2'd1; lat = 4; end
      else if (!allowed(e2[8:6], acc)) begin ef = 2'd2; lat = 4; end
      else begin ef = 2'd0; lat = 5; wb = 1; ep = {11'h0, e2[31:10], va[12:0]}; end
    end
    if (wb) wd = ent | 32'h10 | ((acc == 2'd1) ? 32'h20 : 32'h0);
    rd_cnt = 0; wr_cnt = 0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_cid = cid; req_acc = acc; req_seg = seg;
    @(posedge clk); #1;
    req_valid = 1'b0;
    k = 0; got = 0;
    while (!got && k < 400) begin
      @(posedge clk); k++; #1;
      if (done) got = 1;
    end
    if (!got) begin
      chk(1'b0, "R9 done timeout", 64'(k), 64'(lat));
      return;
    end
    t = (ef == 2'd2) ? "R6" : (ef == 2'd1) ? "R5" : (seg ? "R4" : "R3");
    chk(rsp_fault == ef, {t, " fault code"}, 64'(rsp_fault), 64'(ef));
    chk(rsp_paddr == ep, {seg ? "R4" : "R3", " paddr"}, 64'(rsp_paddr), 64'(ep));
    if (!stall_en) chk(k == lat, "R10 latency", 64'(k), 64'(lat));
    chk(rd_cnt == nrd, stall_en ? "R8 read count" : (seg ? "R4 read count" : "R3 read count"),
        64'(rd_cnt), 64'(nrd));
    chk(wr_cnt == (wb ? 1 : 0), wb ? "R7 write count" : "R5 R6 no write", 64'(wr_cnt), 64'(wb));
    if (wb) begin
      chk(last_wa == wa, seg ? "R1 entry address" : "R2 entry address", 64'(last_wa), 64'(wa));
      chk(last_wd == wd, "R7 write-back data", 64'(last_wd), 64'(wd));
    end else if (ef == 2'd2) begin
      chk(rd(wa) == ent, "R6 entry unchanged", 64'(rd(wa)), 64'(ent));
    end
    chk(busy == 1'b1, "R9 busy during done", 64'(busy), 64'd1);
    @(posedge clk); #1;
    chk(!busy && !done && req_ready, "R9 release", {61'h0, busy, done, req_ready}, 64'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_cid = '0; req_acc = '0; req_seg = 1'b0;
    mem_req_ready = 1'b1; mem_rsp_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(req_ready && !busy && !done && !mem_req_valid, "R9 reset state",
        {60'h0, req_ready, busy, done, mem_req_valid}, 64'h8);

    // R3 plain read through both levels
    place(32'hABCD_E123, 4'd5, 0, mk(22'h00_1234, 3'b000, 6'h0), mk(22'h3A_BCDE, 3'b001, 6'h0F));
    walk(32'hABCD_E123, 4'd5, 2'd0, 0);
    // R7 write sets dirty
    place(32'h1200_4000, 4'd2, 0, mk(22'h00_0800, 3'b000, 6'h0), mk(22'h11_1111, 3'b010, 6'h05));
    walk(32'h1200_4000, 4'd2, 2'd1, 0);
    // R6 write to read-only page
    place(32'h3300_2000, 4'd1, 0, mk(22'h00_0400, 3'b111, 6'h0), mk(22'h22_2222, 3'b101, 6'h00));
    walk(32'h3300_2000, 4'd1, 2'd1, 0);
    // R5 invalid first level
    place(32'h4400_0000, 4'd3, 0, mk(22'h0, 3'b111, 6'h3F), 32'h0);
    walk(32'h4400_0000, 4'd3, 2'd0, 0);
    // R5 invalid second level
    place(32'h5500_6000, 4'd4, 0, mk(22'h00_0100, 3'b111, 6'h0), mk(22'h0, 3'b111, 6'h0));
    walk(32'h5500_6000, 4'd4, 2'd0, 0);
    // R4 segment execute
    place(32'h66AB_CDEF, 4'd6, 1, mk(22'h2A_AAAA, 3'b100, 6'h0A), 32'h0);
    walk(32'h66AB_CDEF, 4'd6, 2'd2, 1);
    // R6 reserved access code
    place(32'h7700_0000, 4'd7, 1, mk(22'h00_0001, 3'b111, 6'h0), 32'h0);
    walk(32'h7700_0000, 4'd7, 2'd3, 1);
    // R1 R2 highest indices
    place(32'hFFFF_FFFF, 4'hF, 0, mk(22'h3F_FFFF, 3'b000, 6'h0), mk(22'h3F_FFFF, 3'b111, 6'h30));
    walk(32'hFFFF_FFFF, 4'hF, 2'd1, 0);

    // constrained random, first with memory stalls (R8), then without
    for (int i = 0; i < 360; i++) begin
      logic [31:0] va;
      logic [3:0] cid;
      bit seg;
      logic [1:0] acc;
      stall_en = (i < 80);
      va  = $urandom;
      cid = 4'($urandom);
      seg = ($urandom_range(0, 3) == 0);
      acc = 2'($urandom_range(0, 3));
      place(va, cid, seg, rnd_ent($urandom_range(0, 7) == 0), rnd_ent($urandom_range(0, 7) == 0));
      walk(va, cid, acc, seg);
    end
    stall_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule